// File: doc/BRIEF.md
# Transfer Completion and Reset Controller

This block sits on the data side of an SD/MMC host. It buffers words between the card side and a host/DMA side in one shared FIFO, watches for the end of a card data transfer, and raises two sticky interrupts: transfer-over and receive-watermark. The point at which transfer-over fires depends on the mode. In polled mode it fires as soon as the card side finishes. In DMA mode on a card read it waits until every buffered word has been moved out to memory. A simple request/acknowledge port stands in for the DMA engine. `dma_req` asks for beats, and each `host_strobe` moves one word.

The transfer length is counted in FIFO words. A length of zero means the length is not fixed. On DMA writes of that kind, requests continue until transfer-over is flagged. Software can start three separate self-clearing resets. Each reset holds its busy flag for a fixed pulse of `RST_PULSE` cycles (two by default) and affects only its own part of the block: the transfer state machine, the FIFO contents, or the DMA request side.

Top module: `xfer_done_ctrl`

## Requirements
- R1: After `rst`, both interrupts, `dma_req`, `xfer_busy`, all three busy flags and `fifo_level` read 0.
- R2: The FIFO holds 2^ADDR_W words and returns them in the order written. A popped word appears on `host_rdata` (read direction) or `card_dout` (write direction) in the cycle after the strobe. A push into a full FIFO is dropped, and `fifo_level` never exceeds the depth.
- R3: In polled mode (`cfg_dma_en`=0) with a transfer running, `card_end` sets `irq_dto` at the next clock edge and returns `xfer_busy` to 0, even while words remain in the FIFO.
- R4: `irq_rxwm` is set only in polled read mode (`cfg_dir_wr`=0), in the cycle after `fifo_level` exceeds `cfg_rx_wm`. A tail left at or below the watermark never sets it.
- R5: In DMA read mode `irq_dto` stays 0 after `card_end` until the FIFO is empty. It sets one cycle after the edge that pops the last word.
- R6: In DMA read mode `dma_req` is 1 when the FIFO holds more than `cfg_rx_wm` words during the transfer, or any word at all once the card side has ended or the transfer was stopped. The request register adds one cycle of latency.
- R7: In DMA write mode with `cfg_len` nonzero, `dma_req` is 1 while `fifo_level` <= `cfg_tx_wm` and fewer than `cfg_len` words have been accepted. It drops at the edge that accepts the last word.
- R8: In DMA write mode with `cfg_len`=0, `dma_req` continues past any word count and drops in the cycle after `irq_dto` is set.
- R9: The interrupts are sticky. `int_clr` bit 0 clears `irq_dto` and bit 1 clears `irq_rxwm`. If a set condition and a clear fall in the same cycle, the set wins.
- R10: `ctrl_rst_set` holds `ctrl_rst_busy` for two cycles and returns the transfer to idle (`xfer_busy`=0) without raising `irq_dto`. `fifo_level` is unchanged, and in DMA read mode `dma_req` goes on draining the words left.
- R11: `fifo_rst_set` holds `fifo_rst_busy` for two cycles, then clears it. By the second busy cycle `fifo_level` is 0. A strobe during the reset completes but moves no data, and its read word is 0.
- R12: `dma_rst_set` forces `dma_req` to 0 from the edge that samples it, holds `dma_rst_busy` for two cycles, and clears the accepted-word count. Requests resume afterwards if the transfer still needs them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_len | input | LEN_W | Transfer length in words, 0 = not fixed |
| cfg_dir_wr | input | 1 | 1 = write to card, 0 = read from card |
| cfg_dma_en | input | 1 | 1 = DMA mode, 0 = polled |
| cfg_rx_wm | input | ADDR_W+1 | Receive watermark level |
| cfg_tx_wm | input | ADDR_W+1 | Transmit watermark level |
| xfer_start | input | 1 | Start a data transfer |
| card_push | input | 1 | Card delivers a word (read direction) |
| card_din | input | DATA_W | Word from the card |
| card_pop | input | 1 | Card takes a word (write direction) |
| card_dout | output | DATA_W | Word to the card |
| card_end | input | 1 | Card-side transfer finished |
| host_strobe | input | 1 | One host/DMA beat |
| host_wdata | input | DATA_W | Word from memory (write direction) |
| host_rdata | output | DATA_W | Word to memory (read direction) |
| dma_req | output | 1 | DMA beat request |
| ctrl_rst_set | input | 1 | Start controller reset |
| fifo_rst_set | input | 1 | Start FIFO reset |
| dma_rst_set | input | 1 | Start DMA reset |
| ctrl_rst_busy | output | 1 | Controller reset in progress |
| fifo_rst_busy | output | 1 | FIFO reset in progress |
| dma_rst_busy | output | 1 | DMA reset in progress |
| int_clr | input | 2 | Write-one-to-clear: bit 0 dto, bit 1 rxwm |
| irq_dto | output | 1 | Transfer-over interrupt |
| irq_rxwm | output | 1 | Receive-watermark interrupt |
| fifo_level | output | ADDR_W+1 | Words held in the FIFO |
| xfer_busy | output | 1 | Transfer state machine not idle |

## Verification
Two pairs of events can fall in the same cycle. The first is an interrupt's set condition and its write-one clear. The bench provokes this by asserting `card_end` and `int_clr[0]` together, and by clearing `irq_rxwm` while the FIFO is still above the watermark; in both cases the bit must stay set. The second is a FIFO reset and a host beat. The bench strobes during the reset window and the scoreboard expects a zero word, with the level reading 0 afterwards.

// File: rtl/xdc_pkg.sv
package xdc_pkg;
  typedef enum logic [1:0] {
    XS_IDLE   = 2'd0,
    XS_ACTIVE = 2'd1,
    XS_DRAIN  = 2'd2
  } xfer_state_e;

  localparam int RST_CTRL = 0;
  localparam int RST_FIFO = 1;
  localparam int RST_DMA  = 2;
  localparam int RST_NUM  = 3;
endpackage

// File: rtl/xdc_fifo.sv
module xdc_fifo #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop,
  output logic [DATA_W-1:0] pop_data,
  output logic [ADDR_W:0]   level,
  output logic              full,
  output logic              empty
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [ADDR_W:0] FULL_LVL = (ADDR_W+1)'(DEPTH);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [ADDR_W-1:0] wr_ptr, rd_ptr;
  logic [ADDR_W:0]   cnt;
  logic              push_ok, pop_ok;

  assign full    = (cnt == FULL_LVL);
  assign empty   = (cnt == '0);
  assign push_ok = push & ~full;
  assign pop_ok  = pop & ~empty;
  assign level   = cnt;

  // storage: write port only, no reset, so it maps onto block RAM
  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= push_data;
  end

  // registered read port
  always_ff @(posedge clk) begin
    if (rst || flush)  pop_data <= '0;
    else if (pop_ok)   pop_data <= mem[rd_ptr];
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (push_ok) wr_ptr <= wr_ptr + 1'b1;
      if (pop_ok)  rd_ptr <= rd_ptr + 1'b1;
      case ({push_ok, pop_ok})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/xdc_rst_pulse.sv
module xdc_rst_pulse #(
  parameter int PULSE_LEN = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic set,
  output logic busy
);
  localparam int CW = $clog2(PULSE_LEN + 1);
  localparam logic [CW-1:0] LOAD = CW'(PULSE_LEN);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (set)         cnt <= LOAD;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != '0);
endmodule

// File: rtl/xdc_xfer_fsm.sv
module xdc_xfer_fsm
  import xdc_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  input  logic        card_end,
  input  logic        dir_wr,
  input  logic        dma_en,
  input  logic        fifo_empty,
  input  logic        abort,
  output xfer_state_e state,
  output logic        done_fire
);
  xfer_state_e nxt;

  always_comb begin
    nxt       = state;
    done_fire = 1'b0;
    case (state)
      XS_IDLE:   if (start) nxt = XS_ACTIVE;
      XS_ACTIVE: begin
        if (card_end) begin
          if (!dir_wr && dma_en) begin
            nxt = XS_DRAIN;
          end else begin
            nxt       = XS_IDLE;
            done_fire = 1'b1;
          end
        end
      end
      XS_DRAIN: begin
        if (fifo_empty) begin
          nxt       = XS_IDLE;
          done_fire = 1'b1;
        end
      end
      default:   nxt = XS_IDLE;
    endcase
    if (abort) begin
      nxt       = XS_IDLE;
      done_fire = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) state <= XS_IDLE;
    else     state <= nxt;
  end
endmodule

// File: rtl/xdc_dma_req.sv
module xdc_dma_req #(
  parameter int LEN_W  = 16,
  parameter int ADDR_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             dma_en,
  input  logic             dir_wr,
  input  logic             xfer_active,
  input  logic             start,
  input  logic             beat,
  input  logic [LEN_W-1:0] xfer_len,
  input  logic [ADDR_W:0]  level,
  input  logic [ADDR_W:0]  rx_wm,
  input  logic [ADDR_W:0]  tx_wm,
  input  logic             dto_status,
  input  logic             abort,
  output logic             dma_req
);
  logic [LEN_W-1:0] supplied, supplied_nxt;
  logic             open_len, wr_more, wr_want, rd_want, req_d;

  always_comb begin
    supplied_nxt = supplied;
    if (abort || start) supplied_nxt = '0;
    else if (beat)      supplied_nxt = supplied + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) supplied <= '0;
    else     supplied <= supplied_nxt;
  end

  assign open_len = (xfer_len == '0);
  assign wr_more  = open_len ? ~dto_status : (supplied_nxt < xfer_len);
  assign wr_want  = xfer_active & (level <= tx_wm) & wr_more;
  assign rd_want  = (level != '0) & ((level > rx_wm) | ~xfer_active);
  assign req_d    = dma_en & ~abort & (dir_wr ? wr_want : rd_want);

  always_ff @(posedge clk) begin
    if (rst) dma_req <= 1'b0;
    else     dma_req <= req_d;
  end
endmodule

// File: rtl/xfer_done_ctrl.sv
module xfer_done_ctrl
  import xdc_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 3,
  parameter int LEN_W     = 16,
  parameter int RST_PULSE = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [LEN_W-1:0]  cfg_len,
  input  logic              cfg_dir_wr,
  input  logic              cfg_dma_en,
  input  logic [ADDR_W:0]   cfg_rx_wm,
  input  logic [ADDR_W:0]   cfg_tx_wm,
  input  logic              xfer_start,
  input  logic              card_push,
  input  logic [DATA_W-1:0] card_din,
  input  logic              card_pop,
  output logic [DATA_W-1:0] card_dout,
  input  logic              card_end,
  input  logic              host_strobe,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  output logic              dma_req,
  input  logic              ctrl_rst_set,
  input  logic              fifo_rst_set,
  input  logic              dma_rst_set,
  output logic              ctrl_rst_busy,
  output logic              fifo_rst_busy,
  output logic              dma_rst_busy,
  input  logic [1:0]        int_clr,
  output logic              irq_dto,
  output logic              irq_rxwm,
  output logic [ADDR_W:0]   fifo_level,
  output logic              xfer_busy
);
  logic [RST_NUM-1:0] rst_set_vec, rst_busy_vec;
  logic               push_req, pop_req, push_en, pop_en;
  logic [DATA_W-1:0]  push_data, pop_data;
  logic               fifo_full, fifo_empty;
  xfer_state_e        state;
  logic               done_fire, dma_abort, rxwm_hit;

  // ---- self-clearing reset pulses ----
  assign rst_set_vec[RST_CTRL] = ctrl_rst_set;
  assign rst_set_vec[RST_FIFO] = fifo_rst_set;
  assign rst_set_vec[RST_DMA]  = dma_rst_set;

  for (genvar gi = 0; gi < RST_NUM; gi++) begin : g_rst
    xdc_rst_pulse #(.PULSE_LEN(RST_PULSE)) u_pulse (
      .clk  (clk),
      .rst  (rst),
      .set  (rst_set_vec[gi]),
      .busy (rst_busy_vec[gi])
    );
  end

  assign ctrl_rst_busy = rst_busy_vec[RST_CTRL];
  assign fifo_rst_busy = rst_busy_vec[RST_FIFO];
  assign dma_rst_busy  = rst_busy_vec[RST_DMA];

  // ---- FIFO port steering by direction ----
  assign push_req  = cfg_dir_wr ? host_strobe : card_push;
  assign push_data = cfg_dir_wr ? host_wdata  : card_din;
  assign pop_req   = cfg_dir_wr ? card_pop    : host_strobe;
  assign push_en   = push_req & ~fifo_rst_busy;
  assign pop_en    = pop_req  & ~fifo_rst_busy;

  xdc_fifo #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_fifo (
    .clk       (clk),
    .rst       (rst),
    .flush     (fifo_rst_busy),
    .push      (push_en),
    .push_data (push_data),
    .pop       (pop_en),
    .pop_data  (pop_data),
    .level     (fifo_level),
    .full      (fifo_full),
    .empty     (fifo_empty)
  );

  assign host_rdata = cfg_dir_wr ? '0 : pop_data;
  assign card_dout  = cfg_dir_wr ? pop_data : '0;

  // ---- transfer state ----
  xdc_xfer_fsm u_fsm (
    .clk        (clk),
    .rst        (rst),
    .start      (xfer_start),
    .card_end   (card_end),
    .dir_wr     (cfg_dir_wr),
    .dma_en     (cfg_dma_en),
    .fifo_empty (fifo_empty),
    .abort      (ctrl_rst_busy),
    .state      (state),
    .done_fire  (done_fire)
  );

  assign xfer_busy = (state != XS_IDLE);

  // ---- DMA requester ----
  assign dma_abort = dma_rst_set | dma_rst_busy;

  xdc_dma_req #(.LEN_W(LEN_W), .ADDR_W(ADDR_W)) u_dma (
    .clk         (clk),
    .rst         (rst),
    .dma_en      (cfg_dma_en),
    .dir_wr      (cfg_dir_wr),
    .xfer_active (state == XS_ACTIVE),
    .start       (xfer_start),
    .beat        (push_en & ~fifo_full & cfg_dir_wr),
    .xfer_len    (cfg_len),
    .level       (fifo_level),
    .rx_wm       (cfg_rx_wm),
    .tx_wm       (cfg_tx_wm),
    .dto_status  (irq_dto),
    .abort       (dma_abort),
    .dma_req     (dma_req)
  );

  // ---- sticky interrupts, set beats clear ----
  assign rxwm_hit = ~cfg_dma_en & ~cfg_dir_wr & (fifo_level > cfg_rx_wm);

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_dto  <= 1'b0;
      irq_rxwm <= 1'b0;
    end else begin
      if (done_fire)       irq_dto <= 1'b1;
      else if (int_clr[0]) irq_dto <= 1'b0;
      if (rxwm_hit)        irq_rxwm <= 1'b1;
      else if (int_clr[1]) irq_rxwm <= 1'b0;
    end
  end
endmodule

// File: rtl/xdc_checker.sv
module xdc_checker #(
  parameter int ADDR_W = 3,
  parameter int LEN_W  = 16
) (
  input logic             clk,
  input logic             rst,
  input logic [LEN_W-1:0] cfg_len,
  input logic             cfg_dir_wr,
  input logic             cfg_dma_en,
  input logic [1:0]       int_clr,
  input logic             irq_dto,
  input logic             dma_req,
  input logic             ctrl_rst_busy,
  input logic             fifo_rst_busy,
  input logic             dma_rst_set,
  input logic             dma_rst_busy,
  input logic [ADDR_W:0]  fifo_level,
  input logic             xfer_busy
);
  localparam logic [ADDR_W:0] FULL_LVL = (ADDR_W+1)'(1 << ADDR_W);

  assert_level_bound_R2: assert property (@(posedge clk) disable iff (rst)
    fifo_level <= FULL_LVL);

  assert_dto_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    (irq_dto && !int_clr[0]) |=> irq_dto);

  assert_ctrl_idle_R10: assert property (@(posedge clk) disable iff (rst)
    ctrl_rst_busy |=> !xfer_busy);

  assert_fifo_flush_R11: assert property (@(posedge clk) disable iff (rst)
    fifo_rst_busy |=> (fifo_level == '0));

  assert_dma_quiet_R12: assert property (@(posedge clk) disable iff (rst)
    (dma_rst_set || dma_rst_busy) |=> !dma_req);

  assert_open_stop_R8: assert property (@(posedge clk) disable iff (rst)
    (cfg_dma_en && cfg_dir_wr && cfg_len == '0 && irq_dto) |=> !dma_req);
endmodule

bind xfer_done_ctrl xdc_checker #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .cfg_len       (cfg_len),
  .cfg_dir_wr    (cfg_dir_wr),
  .cfg_dma_en    (cfg_dma_en),
  .int_clr       (int_clr),
  .irq_dto       (irq_dto),
  .dma_req       (dma_req),
  .ctrl_rst_busy (ctrl_rst_busy),
  .fifo_rst_busy (fifo_rst_busy),
  .dma_rst_set   (dma_rst_set),
  .dma_rst_busy  (dma_rst_busy),
  .fifo_level    (fifo_level),
  .xfer_busy     (xfer_busy)
);

// File: tb/xfer_done_ctrl_tb.sv
`timescale 1ns/1ps
module xfer_done_ctrl_tb;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 3;
  localparam int LEN_W  = 16;

  logic              clk = 1'b0;
  logic              rst;
  logic [LEN_W-1:0]  cfg_len;
  logic              cfg_dir_wr, cfg_dma_en;
  logic [ADDR_W:0]   cfg_rx_wm, cfg_tx_wm;
  logic              xfer_start, card_push, card_pop, card_end, host_strobe;
  logic [DATA_W-1:0] card_din, card_dout, host_wdata, host_rdata;
  logic              dma_req;
  logic              ctrl_rst_set, fifo_rst_set, dma_rst_set;
  logic              ctrl_rst_busy, fifo_rst_busy, dma_rst_busy;
  logic [1:0]        int_clr;
  logic              irq_dto, irq_rxwm, xfer_busy;
  logic [ADDR_W:0]   fifo_level;

  int n_chk = 0;
  int n_bad = 0;
  logic [DATA_W-1:0] exp_q[$];
  logic rd_q = 1'b0;

  always #2.5 clk = ~clk;

  xfer_done_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_dut (
    .clk(clk), .rst(rst), .cfg_len(cfg_len), .cfg_dir_wr(cfg_dir_wr),
    .cfg_dma_en(cfg_dma_en), .cfg_rx_wm(cfg_rx_wm), .cfg_tx_wm(cfg_tx_wm),
    .xfer_start(xfer_start), .card_push(card_push), .card_din(card_din),
    .card_pop(card_pop), .card_dout(card_dout), .card_end(card_end),
    .host_strobe(host_strobe), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .dma_req(dma_req), .ctrl_rst_set(ctrl_rst_set), .fifo_rst_set(fifo_rst_set),
    .dma_rst_set(dma_rst_set), .ctrl_rst_busy(ctrl_rst_busy),
    .fifo_rst_busy(fifo_rst_busy), .dma_rst_busy(dma_rst_busy),
    .int_clr(int_clr), .irq_dto(irq_dto), .irq_rxwm(irq_rxwm),
    .fifo_level(fifo_level), .xfer_busy(xfer_busy)
  );

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic card_in(logic [DATA_W-1:0] d);
    card_push = 1'b1; card_din = d; step(); card_push = 1'b0;
  endtask

  task automatic card_out(logic [DATA_W-1:0] exp);
    card_pop = 1'b1; step(); card_pop = 1'b0;
    check("R2 card word", card_dout, exp);
  endtask

  task automatic host_rd(logic [DATA_W-1:0] exp);
    exp_q.push_back(exp);
    host_strobe = 1'b1; step(); host_strobe = 1'b0;
  endtask

  task automatic host_wr(logic [DATA_W-1:0] d);
    host_wdata = d; host_strobe = 1'b1; step(); host_strobe = 1'b0;
  endtask

  task automatic pulse_start();
    xfer_start = 1'b1; step(); xfer_start = 1'b0;
  endtask

  task automatic pulse_end();
    card_end = 1'b1; step(); card_end = 1'b0;
  endtask

  task automatic clear_irq(logic [1:0] m);
    int_clr = m; step(); int_clr = 2'b00;
  endtask

  task automatic ctrl_reset();
    ctrl_rst_set = 1'b1; step(); ctrl_rst_set = 1'b0; step(); step();
  endtask

  task automatic fifo_reset();
    fifo_rst_set = 1'b1; step(); fifo_rst_set = 1'b0; step(); step();
  endtask

  // scoreboard monitor for host reads
  always @(posedge clk) rd_q <= host_strobe & ~cfg_dir_wr;

  always @(negedge clk) begin
    if (rd_q) begin
      if (exp_q.size() == 0) begin
        check("R2 or R11 unexpected host read", 64'd1, 64'd0);
      end else begin
        logic [DATA_W-1:0] e;
        e = exp_q.pop_front();
        check("R2 or R11 host read word", host_rdata, e);
      end
    end
  end

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    rst = 1'b1; cfg_len = '0; cfg_dir_wr = 1'b0; cfg_dma_en = 1'b0;
    cfg_rx_wm = 4'd3; cfg_tx_wm = 4'd2;
    xfer_start = 0; card_push = 0; card_pop = 0; card_end = 0; host_strobe = 0;
    card_din = '0; host_wdata = '0; ctrl_rst_set = 0; fifo_rst_set = 0;
    dma_rst_set = 0; int_clr = 2'b00;
    repeat (3) step();
    rst = 1'b0; step();

    // R1 reset state
    check("R1 irq_dto", irq_dto, 0);
    check("R1 irq_rxwm", irq_rxwm, 0);
    check("R1 dma_req", dma_req, 0);
    check("R1 level", fifo_level, 0);
    check("R1 busy flags", {ctrl_rst_busy, fifo_rst_busy, dma_rst_busy, xfer_busy}, 0);

    // polled read, data left behind at transfer end
    cfg_len = 16'd4;
    pulse_start();
    check("R3 transfer running", xfer_busy, 1);
    for (int i = 0; i < 3; i++) card_in(32'hA000_0000 + i);
    check("R2 level after three", fifo_level, 3);
    step();
    check("R4 at watermark stays low", irq_rxwm, 0);
    card_in(32'hA000_0003);
    check("R2 level after four", fifo_level, 4);
    step();
    check("R4 above watermark sets", irq_rxwm, 1);
    pulse_end();
    check("R3 dto at card end", irq_dto, 1);
    check("R3 data still buffered", fifo_level, 4);
    check("R3 idle after end", xfer_busy, 0);
    clear_irq(2'b11);
    check("R9 dto cleared", irq_dto, 0);
    check("R9 rxwm set wins over clear", irq_rxwm, 1);
    for (int i = 0; i < 4; i++) host_rd(32'hA000_0000 + i);
    check("R2 drained", fifo_level, 0);
    clear_irq(2'b10);
    check("R9 rxwm cleared", irq_rxwm, 0);

    // partial tail never trips watermark
    cfg_len = '0;
    pulse_start();
    card_in(32'hE000_0000); card_in(32'hE000_0001);
    pulse_end();
    check("R3 dto on short read", irq_dto, 1);
    step();
    check("R4 tail below watermark", irq_rxwm, 0);
    host_rd(32'hE000_0000); host_rd(32'hE000_0001);
    clear_irq(2'b01);

    // dto set and clear in the same cycle
    pulse_start();
    card_end = 1'b1; int_clr = 2'b01; step(); card_end = 1'b0; int_clr = 2'b00;
    check("R9 dto set wins over clear", irq_dto, 1);
    clear_irq(2'b01);
    check("R9 dto clear after", irq_dto, 0);

    // full FIFO, then FIFO reset with a beat inside the window
    pulse_start();
    for (int i = 0; i < 9; i++) card_in(32'hF000_0000 + i);
    check("R2 full level", fifo_level, 8);
    fifo_rst_set = 1'b1; step(); fifo_rst_set = 1'b0;
    check("R11 busy raised", fifo_rst_busy, 1);
    host_rd(32'h0);
    check("R11 level emptied", fifo_level, 0);
    check("R11 still busy", fifo_rst_busy, 1);
    step();
    check("R11 self-cleared", fifo_rst_busy, 0);
    ctrl_reset();
    clear_irq(2'b11);

    // DMA read: dto held until drained
    cfg_dma_en = 1'b1;
    pulse_start();
    for (int i = 0; i < 3; i++) card_in(32'hB000_0000 + i);
    step();
    check("R6 no request at watermark", dma_req, 0);
    card_in(32'hB000_0003);
    step();
    check("R6 request above watermark", dma_req, 1);
    check("R4 no rxwm in DMA mode", irq_rxwm, 0);
    host_rd(32'hB000_0000);
    step();
    check("R6 request drops at watermark", dma_req, 0);
    pulse_end();
    check("R5 dto held with data", irq_dto, 0);
    step();
    check("R6 drain request after end", dma_req, 1);
    host_rd(32'hB000_0001);
    host_rd(32'hB000_0002);
    check("R5 dto still held", irq_dto, 0);
    host_rd(32'hB000_0003);
    check("R5 dto not before empty seen", irq_dto, 0);
    step();
    check("R5 dto after drain", irq_dto, 1);
    clear_irq(2'b01);

    // controller reset keeps FIFO, DMA drains
    pulse_start();
    card_in(32'hC000_0000); card_in(32'hC000_0001);
    ctrl_rst_set = 1'b1; step(); ctrl_rst_set = 1'b0;
    check("R10 busy raised", ctrl_rst_busy, 1);
    step();
    check("R10 transfer idle", xfer_busy, 0);
    check("R10 FIFO kept", fifo_level, 2);
    step();
    check("R10 busy cleared", ctrl_rst_busy, 0);
    check("R10 DMA keeps draining", dma_req, 1);
    host_rd(32'hC000_0000); host_rd(32'hC000_0001);
    step();
    check("R10 no dto from abort", irq_dto, 0);
    check("R10 request ends when empty", dma_req, 0);

    // DMA write, fixed length
    cfg_dir_wr = 1'b1; cfg_len = 16'd3;
    pulse_start(); step();
    check("R7 write request", dma_req, 1);
    host_wr(32'hD000_0000);
    check("R7 request continues", dma_req, 1);
    host_wr(32'hD000_0001); host_wr(32'hD000_0002);
    check("R7 request stops at length", dma_req, 0);
    check("R2 write level", fifo_level, 3);
    for (int i = 0; i < 3; i++) card_out(32'hD000_0000 + i);
    check("R7 no request after length", dma_req, 0);
    pulse_end();
    check("R3 write dto", irq_dto, 1);
    clear_irq(2'b01);

    // DMA write, open-ended
    cfg_len = '0; cfg_tx_wm = 4'd7;
    pulse_start(); step();
    check("R8 open request", dma_req, 1);
    for (int i = 0; i < 4; i++) host_wr(32'h9000_0000 + i);
    check("R8 request past any count", dma_req, 1);
    pulse_end();
    check("R8 dto set", irq_dto, 1);
    step();
    check("R8 request stops after dto", dma_req, 0);
    fifo_reset();
    clear_irq(2'b01);

    // DMA reset
    pulse_start(); step();
    check("R12 request before reset", dma_req, 1);
    dma_rst_set = 1'b1; step(); dma_rst_set = 1'b0;
    check("R12 request aborted", dma_req, 0);
    check("R12 busy raised", dma_rst_busy, 1);
    step();
    check("R12 request held low", dma_req, 0);
    step();
    check("R12 busy cleared", dma_rst_busy, 0);
    step();
    check("R12 request resumes", dma_req, 1);
    ctrl_reset();
    fifo_reset();
    step(); step();
    check("R2 scoreboard empty", exp_q.size(), 0);

    summary();
    $finish;
  end
endmodule